// File: doc/BRIEF.md
# Two-Real-Spectrum Separation Stage

This stage sits after a complex FFT that was loaded with two unrelated real signals, one in the real input and one in the imaginary input. It takes one complex sample per cycle in which its input valid is high, and it groups consecutive accepted samples into pairs. The first sample of a pair is the even sample and the second is the odd sample. Each pair gives two complex results: a bin of the spectrum of the first real signal and a bin of the spectrum of the second real signal.

Each result component is a sum or a difference of two input components. It is formed signed at one bit wider than the sample and then halved by dropping its least significant bit, so it cannot overflow. The two results of a pair leave one per cycle, the first-signal bin first. A frame of N accepted inputs therefore gives N outputs in the same pair order. Input valid may drop for any number of cycles between samples.

Top module: `dual_real_split`

## Requirements
- R1: Input and output words are packed with the imaginary part in bits [31:16] and the real part in bits [15:0], each a two's-complement 16-bit value.
- R2: After reset, the first accepted sample (in_val high) is the even sample of a pair. Every accepted sample toggles the pair phase.
- R3: The first result of a pair has real part (re(odd)+re(even))>>>1 and imaginary part (im(even)-im(odd))>>>1. Each is computed at 17 bits signed and keeps bits 16..1, so halving rounds toward minus infinity.
- R4: The second result of a pair has real part (im(odd)+im(even))>>>1 and imaginary part (re(odd)-re(even))>>>1, with the same 17-bit arithmetic.
- R5: Full-scale inputs (+32767 and -32768) give exact halved results with no wrap.
- R6: The first result appears on the outputs in the cycle after the clock edge that accepts the odd sample. The second result appears in the following cycle. Back-to-back pairs stream with no stall.
- R7: out_val is high exactly in the cycles that carry a result. In all other cycles out_dat is zero.
- R8: A synchronous reset clears the pair phase, drops any pending second result, and drives out_val and out_dat to zero.
- R9: Cycles with in_val low between samples neither advance the pair phase nor change the held even sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_dat | input | 32 | Packed complex sample {im, re} |
| in_val | input | 1 | Sample on in_dat is accepted this cycle |
| out_dat | output | 32 | Packed complex result {im, re}, zero when idle |
| out_val | output | 1 | out_dat carries a result |

## Verification
A pair phase left in the wrong state mixes samples from two different pairs. This shows up on the very next output as values that fit neither equation set, and it also shifts out_val by a pair. A lost or stuck pending second result shows up one cycle after the first result, either as a missing out_val or as an extra one. A wrong halving or a missing sign bit is exposed by the full-scale and odd-sum vectors on the first output of that pair. Every one of these faults is therefore visible at the ports within two cycles of the odd sample that triggers it.

// File: rtl/split_pkg.sv
package split_pkg;

    localparam int SPLIT_W = 16;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } phase_e;

endpackage

// File: rtl/split_pair_cap.sv
module split_pair_cap
    import split_pkg::*;
#(
    parameter int W = SPLIT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [2*W-1:0] in_dat,
    input  logic           in_val,
    output logic           pair_vld,
    output logic [2*W-1:0] even_dat,
    output logic [2*W-1:0] odd_dat
);

    typedef struct packed {
        phase_e         phase;
        logic [2*W-1:0] even;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (in_val) begin
            if (st_q.phase == PH_EVEN) begin
                st_d.even  = in_dat;
                st_d.phase = PH_ODD;
            end else begin
                st_d.phase = PH_EVEN;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{phase: PH_EVEN, even: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pair_vld = in_val && (st_q.phase == PH_ODD);
    assign even_dat = st_q.even;
    assign odd_dat  = in_dat;

    // R9: idle cycles keep phase and the held even sample
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_val |=> ($stable(st_q.phase) && $stable(st_q.even)));

    // R2: every accepted sample flips the phase
    p_phase_flip_r2: assert property (@(posedge clk) disable iff (rst)
        in_val |=> (st_q.phase != $past(st_q.phase)));

    // R8: the cycle after reset starts at the even sample
    p_reset_even_r8: assert property (@(posedge clk)
        rst |=> (st_q.phase == PH_EVEN));

endmodule

// File: rtl/split_arith.sv
module split_arith #(
    parameter int W = 16
) (
    input  logic [2*W-1:0] even_dat,
    input  logic [2*W-1:0] odd_dat,
    output logic [2*W-1:0] res_first,
    output logic [2*W-1:0] res_second
);

    localparam int LANES = 4;
    localparam int EW    = W + 1;
    // lane: 0 first.re, 1 first.im, 2 second.re, 3 second.im
    localparam logic [LANES-1:0] SUB_MASK = 4'b1010;

    logic signed [W-1:0] e_re, e_im, o_re, o_im;
    logic signed [W-1:0] op_a [LANES];
    logic signed [W-1:0] op_b [LANES];
    logic        [W-1:0] lane_out [LANES];

    assign e_re = even_dat[W-1:0];
    assign e_im = even_dat[2*W-1:W];
    assign o_re = odd_dat[W-1:0];
    assign o_im = odd_dat[2*W-1:W];

    assign op_a[0] = o_re;  assign op_b[0] = e_re;
    assign op_a[1] = e_im;  assign op_b[1] = o_im;
    assign op_a[2] = o_im;  assign op_b[2] = e_im;
    assign op_a[3] = o_re;  assign op_b[3] = e_re;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [EW-1:0] wide_a, wide_b, wide_r;
        assign wide_a = {op_a[g][W-1], op_a[g]};
        assign wide_b = {op_b[g][W-1], op_b[g]};
        if (SUB_MASK[g]) begin : g_sub
            assign wide_r = wide_a - wide_b;
        end else begin : g_add
            assign wide_r = wide_a + wide_b;
        end
        assign lane_out[g] = wide_r[EW-1:1];
    end

    assign res_first  = {lane_out[1], lane_out[0]};
    assign res_second = {lane_out[3], lane_out[2]};

endmodule

// File: rtl/split_seq.sv
module split_seq #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pair_vld,
    input  logic [2*W-1:0] res_first,
    input  logic [2*W-1:0] res_second,
    output logic           out_val,
    output logic [2*W-1:0] out_dat
);

    typedef struct packed {
        logic           val;
        logic [2*W-1:0] dat;
        logic           pend_vld;
        logic [2*W-1:0] pend;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.val = 1'b0;
        st_d.dat = '0;
        if (pair_vld) begin
            st_d.val      = 1'b1;
            st_d.dat      = res_first;
            st_d.pend     = res_second;
            st_d.pend_vld = 1'b1;
        end else if (st_q.pend_vld) begin
            st_d.val      = 1'b1;
            st_d.dat      = st_q.pend;
            st_d.pend_vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_val = st_q.val;
    assign out_dat = st_q.dat;

    // R6: a new pair never meets an unsent second result
    p_no_collide_r6: assert property (@(posedge clk) disable iff (rst)
        !(pair_vld && st_q.pend_vld));

    // R6: second result follows the first one cycle later
    p_second_next_r6: assert property (@(posedge clk) disable iff (rst)
        pair_vld |=> ##1 out_val);

    // R7: idle output word is zero
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !out_val |-> (out_dat == '0));

    // R8: reset silences the output
    p_reset_quiet_r8: assert property (@(posedge clk)
        rst |=> (!out_val && !st_q.pend_vld));

endmodule

// File: rtl/dual_real_split.sv
module dual_real_split
    import split_pkg::*;
#(
    parameter int W = SPLIT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [2*W-1:0] in_dat,
    input  logic           in_val,
    output logic [2*W-1:0] out_dat,
    output logic           out_val
);

    logic           pair_vld;
    logic [2*W-1:0] even_dat, odd_dat;
    logic [2*W-1:0] res_first, res_second;

    split_pair_cap #(.W(W)) cap_i (
        .clk      (clk),
        .rst      (rst),
        .in_dat   (in_dat),
        .in_val   (in_val),
        .pair_vld (pair_vld),
        .even_dat (even_dat),
        .odd_dat  (odd_dat)
    );

    split_arith #(.W(W)) arith_i (
        .even_dat   (even_dat),
        .odd_dat    (odd_dat),
        .res_first  (res_first),
        .res_second (res_second)
    );

    split_seq #(.W(W)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .pair_vld   (pair_vld),
        .res_first  (res_first),
        .res_second (res_second),
        .out_val    (out_val),
        .out_dat    (out_dat)
    );

endmodule

// File: tb/dual_real_split_tb_top.sv
module dual_real_split_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] in_dat = '0;
    logic        in_val = 1'b0;
    logic [31:0] out_dat;
    logic        out_val;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dual_real_split dut_i (
        .clk     (clk),
        .rst     (rst),
        .in_dat  (in_dat),
        .in_val  (in_val),
        .out_dat (out_dat),
        .out_val (out_val)
    );

    // fields: re0, im0, re1, im1, exp first re/im, exp second re/im
    typedef struct packed {
        logic [15:0] re0, im0, re1, im1, ar, ai, br, bi;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [NV] = '{
        '{16'h000A, 16'h0004, 16'h0006, 16'h0002, 16'h0008, 16'h0001, 16'h0003, 16'hFFFE},
        '{16'hFFFD, 16'h0007, 16'h0000, 16'hFFF8, 16'hFFFE, 16'h0007, 16'hFFFF, 16'h0001},
        '{16'h7FFF, 16'h8000, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h0000},
        '{16'h8000, 16'h7FFF, 16'h8000, 16'h8000, 16'h8000, 16'h7FFF, 16'hFFFF, 16'h0000},
        '{16'h0001, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF}
    };

    task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic drv(input logic v, input logic [31:0] d);
        in_val = v;
        in_dat = d;
        @(negedge clk);
    endtask

    function automatic logic [31:0] pk_even(input vec_t v); return {v.im0, v.re0}; endfunction
    function automatic logic [31:0] pk_odd(input vec_t v);  return {v.im1, v.re1}; endfunction
    function automatic logic [32:0] exp_a(input vec_t v);   return {1'b1, v.ai, v.ar}; endfunction
    function automatic logic [32:0] exp_b(input vec_t v);   return {1'b1, v.bi, v.br}; endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 reset outputs", {out_val, out_dat}, 33'h0);
        rst = 1'b0;

        // R1 R3 R4 R5 R6 R7 R9: table walk, gaps of 0..2 idle cycles inside the pair
        for (int i = 0; i < NV; i++) begin
            drv(1'b1, pk_even(VEC[i]));
            for (int g = 0; g < i % 3; g++) begin
                drv(1'b0, 32'hDEAD_BEEF);
                chk("R9 gap keeps output idle", {out_val, out_dat}, 33'h0);
            end
            drv(1'b1, pk_odd(VEC[i]));
            chk($sformatf("R3 R5 R6 first result vec %0d", i), {out_val, out_dat}, exp_a(VEC[i]));
            drv(1'b0, 32'h0);
            chk($sformatf("R4 R5 R6 second result vec %0d", i), {out_val, out_dat}, exp_b(VEC[i]));
            drv(1'b0, 32'h0);
            chk("R7 idle after pair", {out_val, out_dat}, 33'h0);
        end

        // R6: back-to-back pairs stream without stall
        drv(1'b1, pk_even(VEC[0]));
        drv(1'b1, pk_odd(VEC[0]));
        chk("R6 stream first of pair 0", {out_val, out_dat}, exp_a(VEC[0]));
        drv(1'b1, pk_even(VEC[1]));
        chk("R6 stream second of pair 0", {out_val, out_dat}, exp_b(VEC[0]));
        drv(1'b1, pk_odd(VEC[1]));
        chk("R6 stream first of pair 1", {out_val, out_dat}, exp_a(VEC[1]));
        drv(1'b0, 32'h0);
        chk("R6 stream second of pair 1", {out_val, out_dat}, exp_b(VEC[1]));
        drv(1'b0, 32'h0);
        chk("R7 idle after stream", {out_val, out_dat}, 33'h0);

        // R8 R2: reset after a lone even sample restarts pairing
        drv(1'b1, pk_even(VEC[2]));
        rst = 1'b1;
        drv(1'b0, 32'h0);
        rst = 1'b0;
        chk("R8 reset mid pair", {out_val, out_dat}, 33'h0);
        drv(1'b1, pk_even(VEC[0]));
        drv(1'b1, pk_odd(VEC[0]));
        chk("R2 first sample after reset is even", {out_val, out_dat}, exp_a(VEC[0]));
        // R8: reset drops the pending second result
        rst = 1'b1;
        drv(1'b0, 32'h0);
        rst = 1'b0;
        chk("R8 pending second dropped", {out_val, out_dat}, 33'h0);
        drv(1'b0, 32'h0);
        chk("R8 stays idle", {out_val, out_dat}, 33'h0);

        // R2 R9: a long gap with junk data does not disturb the held even sample
        drv(1'b1, pk_even(VEC[4]));
        for (int g = 0; g < 6; g++) drv(1'b0, 32'h1234_5678);
        drv(1'b1, pk_odd(VEC[4]));
        chk("R9 long gap first result", {out_val, out_dat}, exp_a(VEC[4]));
        drv(1'b0, 32'h0);
        chk("R9 long gap second result", {out_val, out_dat}, exp_b(VEC[4]));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule